// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Blanking Controls

This block turns a 4-bit binary-coded decimal value into seven active-low segment drives for a single display digit. Every one of the sixteen input codes has a defined pattern: the ten decimal digits use the usual shapes, though 6 is drawn without its top bar and 9 without its bottom bar. Codes 10 to 14 show distinct fragment shapes, and code 15 shows a dark digit.

Three active-low controls sit on top of the decoder, in a fixed priority. A forced-blank input turns the digit dark. A lamp-test input lights every segment. A ripple-blank input makes a zero go dark and signals this on a ripple-blank output. Chaining the ripple output of one digit into the ripple input of the next suppresses leading or trailing zeros across a row of digits. A bidirectional shared blank/ripple pin is modelled as two ports: the forced-blank input and the ripple-blank output. Board logic may wire-AND them together. Outputs are registered, so they follow the inputs with one clock of latency.

Top module: `bcd7seg_decoder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, seg_n reads 7'h7F (all segments dark) and rbo_n reads 1.
- R2: seg_n and rbo_n reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: Segment drive is active low (0 lights a segment). seg_n bit 6 is segment a, bit 5 is b, and so on down to bit 0, which is g.
- R4: With bi_n, lt_n and rbi_n all high, the codes 0 to 9 light these segments: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 cdefg, 7 abc, 8 abcdefg, 9 abcfg.
- R5: With bi_n, lt_n and rbi_n all high, the codes 10 to 15 light these segments: 10 deg, 11 cdg, 12 bfg, 13 adfg, 14 defg, 15 none.
- R6: A low bi_n darkens every segment, whatever the values of bcd, lt_n and rbi_n.
- R7: With bi_n high and lt_n low, every segment lights, for any bcd and any rbi_n.
- R8: With lt_n high, rbi_n low and bcd equal to 0, every segment is dark and rbo_n is low. This holds for either value of bi_n.
- R9: In every case other than R8, rbo_n is high. For nonzero codes, rbi_n does not change seg_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bcd | input | 4 | Code to display |
| lt_n | input | 1 | Lamp test, active low |
| rbi_n | input | 1 | Ripple-blank input, active low |
| bi_n | input | 1 | Forced blank, active low |
| seg_n | output | 7 | Segment drives a..g on bits 6..0, active low |
| rbo_n | output | 1 | Ripple-blank output, active low, asserted on a suppressed zero |

## Verification
The bench uses the default parameters, with BCD_W at 4. At that width all sixteen codes can be walked against all eight combinations of the three controls. This covers every glyph, the tails missing from 6 and 9, the dark code 15, and every priority conflict between blank, lamp test and zero suppression. Directed steps then cover reset in the middle of a run. They also cover the one-cycle latency when inputs change on consecutive cycles. Finally, the bench feeds rbo_n back through a wired-AND onto bi_n, the way a shared pin behaves on a board.

// File: rtl/bcd7seg_pkg.sv
package bcd7seg_pkg;
    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        seg_t seg_n;
        logic rbo_n;
    } drive_t;

    localparam seg_t SEG_DARK = '1;
    localparam seg_t SEG_FULL = '0;

    // active-high lit mask; bit 6 = a ... bit 0 = g
    function automatic seg_t glyph_lit(input logic [3:0] code);
        seg_t m;
        case (code)
            4'd0:  m = 7'b1111110;
            4'd1:  m = 7'b0110000;
            4'd2:  m = 7'b1101101;
            4'd3:  m = 7'b1111001;
            4'd4:  m = 7'b0110011;
            4'd5:  m = 7'b1011011;
            4'd6:  m = 7'b0011111;
            4'd7:  m = 7'b1110000;
            4'd8:  m = 7'b1111111;
            4'd9:  m = 7'b1110011;
            4'd10: m = 7'b0001101;
            4'd11: m = 7'b0011001;
            4'd12: m = 7'b0100011;
            4'd13: m = 7'b1001011;
            4'd14: m = 7'b0001111;
            default: m = 7'b0000000;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/bcd7seg_glyph.sv
module bcd7seg_glyph
    import bcd7seg_pkg::*;
#(
    parameter int BCD_W = 4
) (
    input  logic [BCD_W-1:0] code,
    output seg_t             pat_n,
    output logic             is_zero
);
    localparam int PAD_W = (BCD_W > 4) ? BCD_W - 4 : 0;

    logic [3:0] code4;

    generate
        if (PAD_W > 0) begin : g_wide
            // codes above the 4-bit range show a dark digit
            logic over;
            assign over  = |code[BCD_W-1:4];
            assign code4 = over ? 4'hF : code[3:0];
        end else begin : g_narrow
            assign code4 = code[3:0];
        end
    endgenerate

    always_comb begin
        pat_n   = ~glyph_lit(code4);
        is_zero = (code == '0);
    end
endmodule

// File: rtl/bcd7seg_ctrl.sv
module bcd7seg_ctrl
    import bcd7seg_pkg::*;
(
    input  seg_t   pat_n,
    input  logic   is_zero,
    input  logic   lt_n,
    input  logic   rbi_n,
    input  logic   bi_n,
    output drive_t drv
);
    logic zero_supp;

    always_comb begin
        zero_supp = lt_n && !rbi_n && is_zero;
        drv.rbo_n = !zero_supp;
        if (!bi_n)
            drv.seg_n = SEG_DARK;
        else if (!lt_n)
            drv.seg_n = SEG_FULL;
        else if (zero_supp)
            drv.seg_n = SEG_DARK;
        else
            drv.seg_n = pat_n;
    end
endmodule

// File: rtl/bcd7seg_decoder.sv
module bcd7seg_decoder
    import bcd7seg_pkg::*;
#(
    parameter int BCD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BCD_W-1:0] bcd,
    input  logic             lt_n,
    input  logic             rbi_n,
    input  logic             bi_n,
    output logic [SEG_W-1:0] seg_n,
    output logic             rbo_n
);
    seg_t   pat_n;
    logic   is_zero;
    drive_t drv;
    drive_t out_d, out_q;

    bcd7seg_glyph #(.BCD_W(BCD_W)) u_glyph (
        .code    (bcd),
        .pat_n   (pat_n),
        .is_zero (is_zero)
    );

    bcd7seg_ctrl u_ctrl (
        .pat_n   (pat_n),
        .is_zero (is_zero),
        .lt_n    (lt_n),
        .rbi_n   (rbi_n),
        .bi_n    (bi_n),
        .drv     (drv)
    );

    always_comb begin
        out_d = drv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.seg_n <= SEG_DARK;
            out_q.rbo_n <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign seg_n = out_q.seg_n;
    assign rbo_n = out_q.rbo_n;

    // R1
    reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (seg_n == SEG_DARK && rbo_n));

    // R6
    force_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bi_n)) |-> seg_n == SEG_DARK);

    // R7
    lamp_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bi_n) && !$past(lt_n)) |-> seg_n == SEG_FULL);

    // R8
    ripple_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rbo_n |-> seg_n == SEG_DARK);

    // R9
    ripple_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(bcd) != '0 || $past(rbi_n) || !$past(lt_n))) |-> rbo_n);
endmodule

// File: tb/bcd7seg_decoder_bench.sv
module bcd7seg_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bcd = 4'd0;
    logic       lt_n = 1'b1;
    logic       rbi_n = 1'b1;
    logic       bi_n = 1'b1;
    logic [6:0] seg_n;
    logic       rbo_n;

    int total = 0;
    int bad = 0;

    // lit masks, bit 6 = a ... bit 0 = g
    localparam logic [6:0] LIT [16] = '{
        7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001,
        7'b0110011, 7'b1011011, 7'b0011111, 7'b1110000,
        7'b1111111, 7'b1110011, 7'b0001101, 7'b0011001,
        7'b0100011, 7'b1001011, 7'b0001111, 7'b0000000
    };

    always #4 clk = ~clk;

    bcd7seg_decoder u_bcd7seg_decoder (
        .clk(clk), .rst_n(rst_n), .bcd(bcd), .lt_n(lt_n),
        .rbi_n(rbi_n), .bi_n(bi_n), .seg_n(seg_n), .rbo_n(rbo_n)
    );

    task automatic check(input string req, input logic [6:0] exp_seg, input logic exp_rbo);
        total++;
        if (seg_n !== exp_seg || rbo_n !== exp_rbo) begin
            bad++;
            $display("FAIL %s bcd=%0d lt_n=%b rbi_n=%b bi_n=%b seg_n=%b rbo_n=%b expected seg_n=%b rbo_n=%b",
                     req, bcd, lt_n, rbi_n, bi_n, seg_n, rbo_n, exp_seg, exp_rbo);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic l, input logic r, input logic b);
        bcd = c; lt_n = l; rbi_n = r; bi_n = b;
    endtask

    function automatic logic [7:0] expect_of(input logic [3:0] c, input logic l,
                                             input logic r, input logic b);
        logic zs;
        logic [6:0] s;
        zs = l && !r && (c == 4'd0);
        if (!b) s = 7'h7F;
        else if (!l) s = 7'h00;
        else if (zs) s = 7'h7F;
        else s = ~LIT[c];
        return {s, !zs};
    endfunction

    function automatic string req_of(input logic [3:0] c, input logic l,
                                     input logic r, input logic b);
        if (!b) return "R6";
        if (!l) return "R7";
        if (c == 4'd0 && !r) return "R8";
        if (c != 4'd0 && !r) return "R9";
        if (c < 4'd10) return "R4";
        return "R5";
    endfunction

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] e;
        logic       pin;
        // R1: during reset
        @(negedge clk); @(negedge clk);
        check("R1", 7'h7F, 1'b1);
        drive(4'd8, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check("R1", 7'h7F, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        // R2/R3: eight shown one cycle after sampling, all bits low
        check("R3", 7'h00, 1'b1);

        // exhaustive walk, R4 R5 R6 R7 R8 R9
        for (int k = 0; k < 128; k++) begin
            drive(k[3:0], k[4], k[5], k[6]);
            @(negedge clk);
            e = expect_of(k[3:0], k[4], k[5], k[6]);
            check(req_of(k[3:0], k[4], k[5], k[6]), e[7:1], e[0]);
        end

        // R2: back-to-back changes, output lags by exactly one cycle
        drive(4'd1, 1'b1, 1'b1, 1'b1);
        @(posedge clk); #1;
        drive(4'd7, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check("R2", ~LIT[1], 1'b1);
        @(negedge clk);
        check("R2", ~LIT[7], 1'b1);

        // R9: ripple input toggled on a nonzero code leaves seg_n alone
        drive(4'd6, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check("R9", ~LIT[6], 1'b1);

        // R8 with wired-AND feedback onto the blank input
        drive(4'd0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            pin = 1'b1 & rbo_n;
            bi_n = pin;
            check("R8", 7'h7F, 1'b0);
        end

        // R1: reset mid-run
        drive(4'd8, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 7'h7F, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", 7'h00, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule